// File: doc/BRIEF.md
# Packed Vector Lane Shifter

This block shifts every lane of a 128-bit vector in a single request. The lanes are 16, 32 or 64 bits wide. It supports logical left, logical right and arithmetic right shifts. The count can come from three places. It can be the low 64 bits of a 128-bit count operand, applied to every lane. It can be an 8-bit immediate, zero-extended and applied to every lane. In variable mode, each lane takes its own count from the matching lane of the count operand.

A shared count is an unsigned 64-bit value and is never masked or wrapped. A count that reaches or passes the lane width gives a zero lane for the logical shifts. For the arithmetic shift it fills the lane with the lane's sign bit.

A two-state controller tracks the result. `ST_IDLE` means no result is on offer, and `ST_DONE` means the result register holds the answer to the request of the previous cycle. The controller has four transitions:
- `IDLE->DONE` on a request.
- `IDLE->IDLE` without one.
- `DONE->DONE` on a back-to-back request.
- `DONE->IDLE` when no request follows.

The result register loads only on a request and otherwise keeps its value.

Top module: `vshift_unit`

## Requirements
- R1: `valid_o` is high in the cycle after each cycle with `req_i` high, and low after a cycle without it. A synchronous reset (`rst_i`) clears `valid_o` and `result_o`.
- R2: `result_o` keeps its value across any cycle in which `req_i` is low.
- R3: Lane size codes are 0 for 16-bit, 1 for 32-bit and 2 for 64-bit lanes. Code 3 behaves as 64-bit. No bit moves from one lane into another.
- R4: Operation codes are 0 for logical left, 1 for logical right and 2 for arithmetic right. Code 3 behaves as logical right.
- R5: With `per_lane_i`=0 and `use_imm_i`=0, all lanes shift by `cnt_vec_i[63:0]`, read as a full unsigned 64-bit value. `cnt_vec_i[127:64]` has no effect.
- R6: With `per_lane_i`=0 and `use_imm_i`=1, all lanes shift by `imm_i` zero-extended to 64 bits. `cnt_vec_i` has no effect.
- R7: With `per_lane_i`=1, lane k shifts by the unsigned value of lane k of `cnt_vec_i`, at the selected lane width. `imm_i` and `use_imm_i` have no effect.
- R8: For a logical shift, a count greater than or equal to the lane width gives an all-zero lane.
- R9: For an arithmetic right shift, a count greater than or equal to the lane width fills the lane with its sign bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Request strobe |
| data_i | input | 128 | Vector to shift |
| cnt_vec_i | input | 128 | Count operand (shared count in [63:0], or per-lane counts) |
| imm_i | input | 8 | Immediate count |
| use_imm_i | input | 1 | Select immediate as the shared count |
| per_lane_i | input | 1 | Variable per-lane count mode |
| lane_sz_i | input | 2 | Lane size code |
| op_i | input | 2 | Operation code |
| result_o | output | 128 | Shifted vector |
| valid_o | output | 1 | Result valid, one cycle after a request |

## Verification
The bench targets counts that a design could wrap by mistake. These are:
- a shared count with only bit 63 set,
- counts equal to the lane width,
- per-lane counts above the lane width.

A design that used only the low bits of the count would return a shifted value instead of zero or sign fill.

Garbage in the upper half of the count operand and in the unused immediate catches a design that reads the wrong count source, because the result then changes. Per-lane counts that differ from lane to lane catch a design that mixes up lane indices. Arithmetic shifts of negative lanes catch sign fill taken from the wrong bit.

Idle cycles between requests catch a result register that reloads without a request.

// File: rtl/vshift_pkg.sv
package vshift_pkg;
    localparam int VEC_W = 128;
    localparam int CNT_W = 64;

    typedef enum logic [1:0] {
        OP_SLL = 2'd0,
        OP_SRL = 2'd1,
        OP_SRA = 2'd2,
        OP_RSV = 2'd3
    } shop_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } state_e;
endpackage

// File: rtl/vshift_lane.sv
module vshift_lane
    import vshift_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]     d_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  shop_e            op_i,
    output logic [W-1:0]     r_o
);
    localparam int SW = $clog2(W);

    logic          sat;
    logic [SW-1:0] sh;
    logic          sgn;

    always_comb begin
        sat = |cnt_i[CNT_W-1:SW];
        sh  = cnt_i[SW-1:0];
        sgn = d_i[W-1];
        case (op_i)
            OP_SLL:  r_o = sat ? '0 : (d_i << sh);
            OP_SRA:  r_o = sat ? {W{sgn}} : W'($signed(d_i) >>> sh);
            default: r_o = sat ? '0 : (d_i >> sh);
        endcase
    end
endmodule

// File: rtl/vshift_bank.sv
module vshift_bank
    import vshift_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [VEC_W-1:0] data_i,
    input  logic [VEC_W-1:0] cnt_vec_i,
    input  logic [CNT_W-1:0] uni_cnt_i,
    input  logic             per_lane_i,
    input  shop_e            op_i,
    output logic [VEC_W-1:0] res_o
);
    localparam int NL = VEC_W / W;

    for (genvar k = 0; k < NL; k++) begin : g_lane
        logic [CNT_W-1:0] lane_cnt;
        always_comb begin
            if (per_lane_i) lane_cnt = CNT_W'(cnt_vec_i[k*W +: W]);
            else            lane_cnt = uni_cnt_i;
        end
        vshift_lane #(.W(W)) u_lane (
            .d_i   (data_i[k*W +: W]),
            .cnt_i (lane_cnt),
            .op_i  (op_i),
            .r_o   (res_o[k*W +: W])
        );
    end
endmodule

// File: rtl/vshift_unit.sv
module vshift_unit
    import vshift_pkg::*;
(
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         req_i,
    input  logic [127:0] data_i,
    input  logic [127:0] cnt_vec_i,
    input  logic [7:0]   imm_i,
    input  logic         use_imm_i,
    input  logic         per_lane_i,
    input  logic [1:0]   lane_sz_i,
    input  logic [1:0]   op_i,
    output logic [127:0] result_o,
    output logic         valid_o
);
    localparam int NB = 3;

    state_e           state_q, state_d;
    logic [CNT_W-1:0] uni_cnt;
    shop_e            op;
    logic [VEC_W-1:0] bank_res [NB];
    logic [VEC_W-1:0] sel_res;

    always_comb begin
        op      = shop_e'(op_i);
        uni_cnt = use_imm_i ? CNT_W'(imm_i) : cnt_vec_i[CNT_W-1:0];
    end

    for (genvar g = 0; g < NB; g++) begin : g_bank
        vshift_bank #(.W(16 << g)) u_bank (
            .data_i     (data_i),
            .cnt_vec_i  (cnt_vec_i),
            .uni_cnt_i  (uni_cnt),
            .per_lane_i (per_lane_i),
            .op_i       (op),
            .res_o      (bank_res[g])
        );
    end

    always_comb begin
        case (lane_sz_i)
            2'd0:    sel_res = bank_res[0];
            2'd1:    sel_res = bank_res[1];
            default: sel_res = bank_res[2];
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_i ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = req_i ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_IDLE;
        else       state_q <= state_d;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)      result_o <= '0;
        else if (req_i) result_o <= sel_res;
    end

    always_comb begin
        valid_o = (state_q == ST_DONE);
    end
endmodule

// File: rtl/vshift_unit_chk.sv
module vshift_unit_chk (
    input logic         clk_i,
    input logic         rst_i,
    input logic         req_i,
    input logic [127:0] data_i,
    input logic [127:0] cnt_vec_i,
    input logic         use_imm_i,
    input logic         per_lane_i,
    input logic [1:0]   lane_sz_i,
    input logic [1:0]   op_i,
    input logic [127:0] result_o,
    input logic         valid_o
);
    AST_VALID_AFTER_REQ: assert property (@(posedge clk_i) disable iff (rst_i)
        req_i |=> valid_o); // R1

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (rst_i)
        !req_i |=> !valid_o); // R1

    AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
        !req_i |=> $stable(result_o)); // R2

    AST_LOGIC_LEFT_SAT: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_i && !per_lane_i && !use_imm_i && op_i == 2'd0 && |cnt_vec_i[63:6])
        |=> result_o == '0); // R8

    AST_ARITH_SAT_WIDE: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_i && !per_lane_i && !use_imm_i && op_i == 2'd2 && lane_sz_i == 2'd2
         && |cnt_vec_i[63:6])
        |=> result_o == {{64{$past(data_i[127])}}, {64{$past(data_i[63])}}}); // R9
endmodule

bind vshift_unit vshift_unit_chk u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .req_i      (req_i),
    .data_i     (data_i),
    .cnt_vec_i  (cnt_vec_i),
    .use_imm_i  (use_imm_i),
    .per_lane_i (per_lane_i),
    .lane_sz_i  (lane_sz_i),
    .op_i       (op_i),
    .result_o   (result_o),
    .valid_o    (valid_o)
);

// File: tb/tb_vshift_unit.sv
`timescale 1ns/1ps
module tb_vshift_unit;
    logic         clk_i = 1'b0;
    logic         rst_i = 1'b1;
    logic         req_i = 1'b0;
    logic [127:0] data_i = '0;
    logic [127:0] cnt_vec_i = '0;
    logic [7:0]   imm_i = '0;
    logic         use_imm_i = 1'b0;
    logic         per_lane_i = 1'b0;
    logic [1:0]   lane_sz_i = '0;
    logic [1:0]   op_i = '0;
    logic [127:0] result_o;
    logic         valid_o;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [127:0] exp_res = '0;
    logic         exp_val = 1'b0;
    string        exp_tag = "R1";

    always #4 clk_i = ~clk_i;

    vshift_unit dut (.*);

    function automatic logic [127:0] model(input logic [127:0] d, input logic [127:0] cv,
            input logic [7:0] imm, input bit ui, input bit pl, input logic [1:0] lsz,
            input logic [1:0] op);
        int w;
        logic [127:0] res;
        logic [63:0] mask, lane, cnt, r;
        bit sgn;
        w = (lsz == 2'd0) ? 16 : (lsz == 2'd1) ? 32 : 64;
        mask = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
        res = '0;
        for (int l = 0; l < 128 / w; l++) begin
            lane = 64'(d >> (l * w)) & mask;
            if (pl)      cnt = 64'(cv >> (l * w)) & mask;
            else if (ui) cnt = {56'd0, imm};
            else         cnt = cv[63:0];
            sgn = lane[w-1];
            if (op == 2'd0)      r = (cnt >= 64'(w)) ? 64'd0 : ((lane << cnt) & mask);
            else if (op == 2'd2) begin
                if (cnt >= 64'(w)) r = sgn ? mask : 64'd0;
                else               r = (lane >> cnt) | (sgn ? (mask & ~(mask >> cnt)) : 64'd0);
            end
            else                 r = (cnt >= 64'(w)) ? 64'd0 : (lane >> cnt);
            res = res | (128'(r) << (l * w));
        end
        return res;
    endfunction

    task automatic check_now();
        tests++;
        if (valid_o !== exp_val || result_o !== exp_res) begin
            fails++;
            $display("FAIL %s: valid=%0b res=%h expected valid=%0b res=%h",
                     exp_tag, valid_o, result_o, exp_val, exp_res);
        end
    endtask

    task automatic step(input bit rq, input logic [127:0] d, input logic [127:0] cv,
            input logic [7:0] imm, input bit ui, input bit pl, input logic [1:0] lsz,
            input logic [1:0] op, input string tag);
        @(negedge clk_i);
        check_now();
        req_i = rq; data_i = d; cnt_vec_i = cv; imm_i = imm;
        use_imm_i = ui; per_lane_i = pl; lane_sz_i = lsz; op_i = op;
        if (rq) exp_res = model(d, cv, imm, ui, pl, lsz, op);
        exp_val = rq;
        exp_tag = tag;
    endtask

    task automatic idle(input string tag);
        step(1'b0, {4{32'hDEAD_BEEF}}, {4{32'h0000_0003}}, 8'h01, 1'b0, 1'b0, 2'd0, 2'd0, tag);
    endtask

    localparam logic [127:0] PAT = 128'h8123_4567_89AB_CDEF_F0E1_D2C3_B4A5_9687;

    initial begin
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        rst_i = 1'b0;
        exp_tag = "R1 reset";
        // reset state: valid low, result zero (R1)
        idle("R1 idle");
        // R3 R4 logical left, 16-bit lanes, shared count 3 (R5)
        step(1, PAT, 128'd3, 8'h00, 0, 0, 2'd0, 2'd0, "R3 R4 R5 sll16");
        // R4 logical right, 32-bit lanes, immediate 5; count operand garbage (R6)
        step(1, PAT, {128{1'b1}}, 8'd5, 1, 0, 2'd1, 2'd1, "R4 R6 srl32 imm");
        // R4 arithmetic right, 64-bit lanes, count 63
        step(1, PAT, 128'd63, 8'h00, 0, 0, 2'd2, 2'd2, "R4 sra64 63");
        // R8 count equal to lane width
        step(1, PAT, 128'd16, 8'h00, 0, 0, 2'd0, 2'd0, "R8 sll16 w");
        // R9 R5 only bit 63 set, unmasked
        step(1, PAT, {64'hFFFF_0000_0000_0000, 64'h8000_0000_0000_0000}, 8'h00, 0, 0, 2'd1, 2'd2, "R9 R5 sra32 bit63");
        // R5 upper half ignored
        step(1, PAT, {64'hFFFF_FFFF_FFFF_FFFF, 64'd1}, 8'hFF, 0, 0, 2'd1, 2'd0, "R5 upper ignored");
        // R7 R8 per-lane 16-bit counts incl. over width; immediate ignored
        step(1, PAT, 128'h0014_0010_000F_0008_0004_0002_0001_0000, 8'd1, 1, 1, 2'd0, 2'd1, "R7 R8 var16");
        // R7 R9 per-lane 64-bit arithmetic, count 100 in upper lane
        step(1, PAT, {64'd100, 64'd7}, 8'd0, 0, 1, 2'd2, 2'd2, "R7 R9 var64 sra");
        // R7 per-lane 32-bit arithmetic with count 32
        step(1, PAT, 128'h0000_0020_0000_001F_0000_0001_0000_0004, 8'd0, 0, 1, 2'd1, 2'd2, "R7 R9 var32 sra");
        // R6 R8 immediate 0xFF
        step(1, PAT, 128'd0, 8'hFF, 1, 0, 2'd2, 2'd1, "R6 R8 imm ff");
        // R4 op code 3; R3 lane code 3
        step(1, PAT, 128'd9, 8'h00, 0, 0, 2'd3, 2'd3, "R3 R4 reserved codes");
        // R2 R1 idle cycles hold result and drop valid
        idle("R2 R1 hold");
        idle("R2 R1 hold");
        step(1, ~PAT, 128'd1, 8'h00, 0, 0, 2'd0, 2'd2, "R1 R9 after idle");
        for (int i = 0; i < 400; i++) begin
            logic [127:0] d, cv;
            logic [63:0] c;
            d  = {$urandom(), $urandom(), $urandom(), $urandom()};
            cv = {$urandom(), $urandom(), $urandom(), $urandom()};
            c  = 64'($urandom_range(0, 80));
            if ($urandom_range(0, 3) != 0) cv[63:0] = c;
            if ($urandom_range(0, 1) != 0) cv = cv & {8{16'h003F}};
            step(1'($urandom_range(0, 3) != 0), d, cv, 8'($urandom()), 1'($urandom()),
                 1'($urandom()), 2'($urandom()), 2'($urandom()), "R3 R4 R5 R6 R7 R8 R9 rand");
        end
        idle("R1 final");
        @(negedge clk_i);
        check_now();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R1: watchdog expired, actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule